// File: doc/BRIEF.md
# Frame and Multiframe Sync Aligner

This block produces two periodic output pulses, a frame pulse and a multiframe pulse, inside one system clock domain. Their rate comes only from a clock-enable tick that is derived from a paired reference clock. Their phase comes from a separate sync input whose rate is lower. The sync input can be a slow signal such as one pulse per second. The block does not track it with a slow loop. Each rising edge of the sync input is compared with the phase that the internal counters expect for that edge. The counters are reloaded only when the edge falls outside a programmable tolerance window.

Two counters hold the phase: one counts ticks within a frame, the other counts frames within a one-second period. The frame output runs at the 8 kHz frame rate or once per second. The multiframe output runs at the rate of four frames (2 kHz) or once per second. If the sync input stops, a sync-loss flag is raised after one expected sync period plus a margin. The outputs keep running from the counters while the flag is set.

Top module: `frame_sync_aligner`

## Requirements
- R1: While `rst_n` is low, `frame_pulse`, `mframe_pulse` and `sync_lost` are all 0.
- R2: When `cfg_frame_pps`=0, `frame_pulse` is 1 for exactly one tick period every FR_TICKS ticks. The outputs change only in cycles where `ref_tick` is 1. Starting from reset, the FR_TICKS-th tick is the first frame pulse.
- R3: When `cfg_mframe_pps`=0, `mframe_pulse` is 1 for one tick period every 4 frames. It always coincides with a frame pulse in the 8 kHz frame mode. Starting from reset, the first multiframe pulse is at tick 4*FR_TICKS.
- R4: When `cfg_frame_pps`=1 or `cfg_mframe_pps`=1, that output pulses once every FR_TICKS*FRAMES_PER_SEC ticks. The phase is the one-second phase of the frame counter.
- R5: `cfg_sync_rate` selects the sync period. 0 is 1 frame, 1 is 2 frames, 2 is 4 frames, 3 is FRAMES_PER_SEC frames (one second). An edge is tested at its consuming tick. The edge is ignored when the position the counters would reach at that tick is within `cfg_tol` ticks of the period start, on either side.
- R6: A sync edge outside the window reloads the counters at its consuming tick, so the frame pulse is 1 at that tick. For rate 3 the frame count becomes 0. For rate 2 the frame count is rounded down to a multiple of 4. With rate 3 and the 8 kHz/2 kHz output modes, the frame and multiframe pulses coincide at that tick.
- R7: A rising edge of `sync_in` in a cycle without a tick is held pending. It is consumed by the next tick.
- R8: `sync_lost` becomes 1 at the tick that is (sync period + MARGIN) ticks after the last consumed sync edge, counted from reset if no edge has been consumed. It is cleared at the next consumed sync edge.
- R9: While `sync_lost` is 1, the frame and multiframe pulses continue at their free-running phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | Clock enable, one cycle per reference tick |
| sync_in | input | 1 | Sync input; rising edge marks period start |
| cfg_sync_rate | input | 2 | Sync period select (0: 1 frame, 1: 2 frames, 2: 4 frames, 3: one second) |
| cfg_frame_pps | input | 1 | Frame output once per second when 1, else every frame |
| cfg_mframe_pps | input | 1 | Multiframe output once per second when 1, else every 4 frames |
| cfg_tol | input | TOL_W | Tolerance window half-width in ticks |
| frame_pulse | output | 1 | Frame sync pulse, one tick wide |
| mframe_pulse | output | 1 | Multiframe sync pulse, one tick wide |
| sync_lost | output | 1 | No sync edge within period plus margin |

## Verification
A wrong tick or frame count shows at the ports on the next frame boundary, at most FR_TICKS ticks later, as a frame pulse at the wrong tick. A fault in the frame count within the second shows within four frames on the multiframe pulse, or within one second in the once-per-second modes. A wrong window decision shows at the consuming tick itself: an edge that should be ignored shifts the pulse grid, and an edge that should realign leaves the grid unchanged. A loss counter that is off by one moves the rise of `sync_lost` by one tick. Each of these is compared with a phase origin that is computed arithmetically from the tick index.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
  typedef enum logic [1:0] {
    SR_FRAME = 2'd0,
    SR_HALF  = 2'd1,
    SR_QUAD  = 2'd2,
    SR_SEC   = 2'd3
  } sync_rate_e;
endpackage

// File: rtl/fsa_phase_ctr.sv
module fsa_phase_ctr
  import fsa_pkg::*;
#(
  parameter int FR_TICKS = 8,
  parameter int FRAMES_PER_SEC = 8000,
  localparam int TW = $clog2(FR_TICKS),
  localparam int FW = $clog2(FRAMES_PER_SEC)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          realign,
  input  sync_rate_e    rate,
  output logic [TW-1:0] tcnt_adv,
  output logic [FW-1:0] fcnt_adv,
  output logic [TW-1:0] tcnt_nx,
  output logic [FW-1:0] fcnt_nx
);
  logic [TW-1:0] tcnt_q;
  logic [FW-1:0] fcnt_q;
  logic          frame_wrap;

  // free-running advance
  always_comb begin
    frame_wrap = (tcnt_q == TW'(FR_TICKS - 1));
    tcnt_adv   = frame_wrap ? '0 : tcnt_q + TW'(1);
    if (frame_wrap)
      fcnt_adv = (fcnt_q == FW'(FRAMES_PER_SEC - 1)) ? '0 : fcnt_q + FW'(1);
    else
      fcnt_adv = fcnt_q;
  end

  // reload to the zero phase of the selected sync period
  always_comb begin
    tcnt_nx = tcnt_adv;
    fcnt_nx = fcnt_adv;
    if (realign) begin
      tcnt_nx = '0;
      unique case (rate)
        SR_FRAME: fcnt_nx = fcnt_q;
        SR_HALF:  fcnt_nx = fcnt_q & ~FW'(1);
        SR_QUAD:  fcnt_nx = fcnt_q & ~FW'(3);
        default:  fcnt_nx = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
      fcnt_q <= '0;
    end else if (tick) begin
      tcnt_q <= tcnt_nx;
      fcnt_q <= fcnt_nx;
    end
  end
endmodule

// File: rtl/fsa_window.sv
module fsa_window
  import fsa_pkg::*;
#(
  parameter int FR_TICKS = 8,
  parameter int FRAMES_PER_SEC = 8000,
  parameter int TOL_W = 4,
  localparam int TW = $clog2(FR_TICKS),
  localparam int FW = $clog2(FRAMES_PER_SEC),
  localparam int PW = $clog2(FR_TICKS * FRAMES_PER_SEC + 1),
  localparam int CW = (PW > TOL_W) ? PW : TOL_W
) (
  input  logic [TW-1:0]    tcnt_adv,
  input  logic [FW-1:0]    fcnt_adv,
  input  sync_rate_e       rate,
  input  logic [TOL_W-1:0] tol,
  output logic [CW-1:0]    period,
  output logic             in_window
);
  logic [FW-1:0] fsel;
  logic [CW-1:0] nframes;
  logic [CW-1:0] pos;
  logic [CW-1:0] tol_e;

  always_comb begin
    unique case (rate)
      SR_FRAME: begin fsel = '0;                 nframes = CW'(1); end
      SR_HALF:  begin fsel = fcnt_adv & FW'(1);  nframes = CW'(2); end
      SR_QUAD:  begin fsel = fcnt_adv & FW'(3);  nframes = CW'(4); end
      default:  begin fsel = fcnt_adv;           nframes = CW'(FRAMES_PER_SEC); end
    endcase
    period    = nframes * CW'(FR_TICKS);
    pos       = CW'(fsel) * CW'(FR_TICKS) + CW'(tcnt_adv);
    tol_e     = CW'(tol);
    in_window = (pos <= tol_e) || ((period - pos) <= tol_e);
  end
endmodule

// File: rtl/fsa_loss_mon.sv
module fsa_loss_mon #(
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          take,
  input  logic [LW-1:0] limit,
  output logic          lost
);
  logic [LW-1:0] cnt_q, cnt_d;
  logic          lost_q, lost_d;

  always_comb begin
    if (take) begin
      cnt_d  = '0;
      lost_d = 1'b0;
    end else begin
      cnt_d  = (cnt_q >= limit) ? cnt_q : cnt_q + LW'(1);
      lost_d = lost_q | (cnt_d >= limit);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      lost_q <= 1'b0;
    end else if (tick) begin
      cnt_q  <= cnt_d;
      lost_q <= lost_d;
    end
  end

  assign lost = lost_q;
endmodule

// File: rtl/frame_sync_aligner.sv
module frame_sync_aligner
  import fsa_pkg::*;
#(
  parameter int FR_TICKS = 8,
  parameter int FRAMES_PER_SEC = 8000,
  parameter int MARGIN = 4,
  parameter int TOL_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic             sync_in,
  input  logic [1:0]       cfg_sync_rate,
  input  logic             cfg_frame_pps,
  input  logic             cfg_mframe_pps,
  input  logic [TOL_W-1:0] cfg_tol,
  output logic             frame_pulse,
  output logic             mframe_pulse,
  output logic             sync_lost
);
  localparam int TW   = $clog2(FR_TICKS);
  localparam int FW   = $clog2(FRAMES_PER_SEC);
  localparam int SEC  = FR_TICKS * FRAMES_PER_SEC;
  localparam int PW   = $clog2(SEC + 1);
  localparam int CW   = (PW > TOL_W) ? PW : TOL_W;
  localparam int LW   = $clog2(SEC + MARGIN + 1);

  sync_rate_e    rate;
  logic          sync_d, pend_q, pend_d;
  logic          sync_rise, sync_take, realign;
  logic [TW-1:0] tcnt_adv, tcnt_nx;
  logic [FW-1:0] fcnt_adv, fcnt_nx;
  logic [CW-1:0] period;
  logic          in_window;
  logic [LW-1:0] loss_limit;
  logic          fr_q, fr_d, mf_q, mf_d;
  logic          at_frame, at_sec;

  assign rate = sync_rate_e'(cfg_sync_rate);

  // sync edge capture, held until the next reference tick
  always_comb begin
    sync_rise = sync_in & ~sync_d;
    sync_take = ref_tick & (sync_rise | pend_q);
    pend_d    = ref_tick ? 1'b0 : (pend_q | sync_rise);
    realign   = sync_take & ~in_window;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_d <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      sync_d <= sync_in;
      pend_q <= pend_d;
    end
  end

  fsa_phase_ctr #(
    .FR_TICKS(FR_TICKS), .FRAMES_PER_SEC(FRAMES_PER_SEC)
  ) u_ctr (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .realign(realign), .rate(rate),
    .tcnt_adv(tcnt_adv), .fcnt_adv(fcnt_adv), .tcnt_nx(tcnt_nx), .fcnt_nx(fcnt_nx)
  );

  fsa_window #(
    .FR_TICKS(FR_TICKS), .FRAMES_PER_SEC(FRAMES_PER_SEC), .TOL_W(TOL_W)
  ) u_win (
    .tcnt_adv(tcnt_adv), .fcnt_adv(fcnt_adv), .rate(rate), .tol(cfg_tol),
    .period(period), .in_window(in_window)
  );

  assign loss_limit = LW'(period) + LW'(MARGIN);

  fsa_loss_mon #(.LW(LW)) u_loss (
    .clk(clk), .rst_n(rst_n), .tick(ref_tick), .take(sync_take),
    .limit(loss_limit), .lost(sync_lost)
  );

  // output pulses follow the phase loaded at each tick
  always_comb begin
    at_frame = (tcnt_nx == '0);
    at_sec   = at_frame && (fcnt_nx == '0);
    fr_d     = cfg_frame_pps ? at_sec : at_frame;
    mf_d     = cfg_mframe_pps ? at_sec : (at_frame && (fcnt_nx[1:0] == 2'b00));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q <= 1'b0;
      mf_q <= 1'b0;
    end else if (ref_tick) begin
      fr_q <= fr_d;
      mf_q <= mf_d;
    end
  end

  assign frame_pulse  = fr_q;
  assign mframe_pulse = mf_q;
endmodule

// File: rtl/frame_sync_aligner_chk.sv
module frame_sync_aligner_chk (
  input logic clk,
  input logic rst_n,
  input logic ref_tick,
  input logic cfg_frame_pps,
  input logic take,
  input logic realign,
  input logic frame_pulse,
  input logic mframe_pulse,
  input logic sync_lost
);
  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> ($stable(frame_pulse) && $stable(mframe_pulse) && $stable(sync_lost)));

  p_mframe_on_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && !cfg_frame_pps) |=> (!mframe_pulse || frame_pulse));

  p_realign_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && realign && !cfg_frame_pps) |=> frame_pulse);

  p_loss_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && take) |=> !sync_lost);

  p_loss_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lost && !(ref_tick && take)) |=> sync_lost);
endmodule

bind frame_sync_aligner frame_sync_aligner_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .cfg_frame_pps(cfg_frame_pps),
  .take(sync_take), .realign(realign), .frame_pulse(frame_pulse),
  .mframe_pulse(mframe_pulse), .sync_lost(sync_lost)
);

// File: tb/frame_sync_aligner_tb_top.sv
module frame_sync_aligner_tb_top;
  localparam int FT  = 4;
  localparam int FPS = 8;
  localparam int MG  = 2;
  localparam int TLW = 3;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, ref_tick, sync_in;
  logic [1:0] rate;
  logic fr_pps, mf_pps;
  logic [TLW-1:0] tol;
  logic fr, mf, loss;

  int checks = 0, fails = 0;
  int t = 0, t0 = 0, ts = 0;
  bit know_mf = 1'b1, know_sec = 1'b1;

  frame_sync_aligner #(.FR_TICKS(FT), .FRAMES_PER_SEC(FPS), .MARGIN(MG), .TOL_W(TLW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .sync_in(sync_in),
    .cfg_sync_rate(rate), .cfg_frame_pps(fr_pps), .cfg_mframe_pps(mf_pps), .cfg_tol(tol),
    .frame_pulse(fr), .mframe_pulse(mf), .sync_lost(loss)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s tick=%0d actual=%b expected=%b", req, what, t, act, exp);
    end
  endtask

  function automatic int per(input logic [1:0] r);
    case (r)
      2'd0: return FT;
      2'd1: return 2 * FT;
      2'd2: return 4 * FT;
      default: return FT * FPS;
    endcase
  endfunction

  // mode 0: plain tick, 1: sync edge with the tick, 2: sync edge one cycle before the tick
  task automatic step(input int mode);
    int p, pos, d;
    bit moved;
    string tag;
    moved = 1'b0;
    if (mode == 2) begin
      @(negedge clk); sync_in = 1'b1; ref_tick = 1'b0;
      @(negedge clk); sync_in = 1'b0; ref_tick = 1'b1;
    end else begin
      @(negedge clk); ref_tick = 1'b1; sync_in = (mode == 1);
    end
    @(negedge clk); ref_tick = 1'b0; sync_in = 1'b0;
    t++;
    if (mode != 0) begin
      p = per(rate);
      pos = (t - t0) % p;
      if (!(pos <= int'(tol) || (p - pos) <= int'(tol))) begin
        moved = 1'b1;
        t0 = t;
        case (rate)
          2'd3: begin know_mf = 1'b1; know_sec = 1'b1; end
          2'd2: begin know_mf = 1'b1; know_sec = 1'b0; end
          default: begin know_mf = 1'b0; know_sec = 1'b0; end
        endcase
      end
      ts = t;
    end
    d = t - t0;
    if (mode == 2) tag = "R7";
    else if (mode == 1) tag = moved ? "R6" : "R5";
    else if ((t - ts) >= per(rate) + MG) tag = "R9";
    else tag = "R2";
    if (fr_pps) begin
      if (know_sec) chk("R4", "frame_pulse pps", fr, (d % (FT * FPS)) == 0);
    end else chk(tag, "frame_pulse", fr, (d % FT) == 0);
    if (mf_pps) begin
      if (know_sec) chk("R4", "mframe_pulse pps", mf, (d % (FT * FPS)) == 0);
    end else if (know_mf) chk(mode != 0 ? tag : "R3", "mframe_pulse", mf, (d % (4 * FT)) == 0);
    chk("R8", "sync_lost", loss, (t - ts) >= per(rate) + MG);
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired at tick=%0d", t);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; ref_tick = 1'b0; sync_in = 1'b0;
    rate = 2'd3; fr_pps = 1'b0; mf_pps = 1'b0; tol = 3'd1;
    // R1: ticks and sync edges during reset leave outputs low
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); ref_tick = i[0]; sync_in = i[1];
      chk("R1", "frame_pulse in reset", fr, 1'b0);
      chk("R1", "mframe_pulse in reset", mf, 1'b0);
      chk("R1", "sync_lost in reset", loss, 1'b0);
    end
    @(negedge clk); ref_tick = 1'b0; sync_in = 1'b0;
    @(negedge clk); rst_n = 1'b1;

    run(44);                 // free run from reset, loss at tick 34 (R2 R3 R8 R9)
    step(1);                 // tick 45: position 13 of 32, realign (R6)
    run(32);                 // ticks 46..77
    step(1);                 // tick 78: position 1, ignored (R5)
    run(29);                 // ticks 79..107
    step(1);                 // tick 108: position 31, ignored (R5)
    fr_pps = 1'b1; mf_pps = 1'b1;
    run(40);                 // once-per-second outputs (R4)
    fr_pps = 1'b0; mf_pps = 1'b0;
    step(2);                 // tick 149: pending edge, position 8, realign (R7)
    rate = 2'd2;
    run(7);                  // ticks 150..156
    step(1);                 // tick 157: position 8 of 16, realign (R6)
    run(24);                 // loss at tick 175 (R8)
    rate = 2'd0;
    step(1);                 // tick 182: position 1 of 4, ignored (R5)
    step(1);                 // tick 183: position 2 of 4, realign (R6)
    run(10);                 // loss at tick 189 (R8)
    tol = 3'd0;
    run(1);                  // tick 194
    step(1);                 // tick 195: position 0, no move even with zero tolerance (R5)
    run(4);
    finish_run();
  end
endmodule